// File: doc/BRIEF.md
# Serial Flash Host Controller

This block connects a 32-bit register bus to a single-lane serial flash. Software loads an instruction, an address and the header byte counts, fills a small write FIFO (or prepares to drain a read FIFO), raises chip select, waits for the ready flag and then sets the start bit. The controller first shifts out the header: a run of instruction bytes, then up to three address bytes. After that it runs the data phase. In write direction it sends bytes from the write FIFO. In read direction it clocks in bytes and pushes them into the read FIFO.

A read either ends after a programmed byte count or runs without limit until software asks it to stop. A stop request, or a release of chip select, takes effect only between bytes. The start bit then clears itself, which tells software the transfer has wound down. A flush request empties both FIFOs in one cycle. The serial clock is the system clock divided by a fixed even parameter. The link idles low, sends the most significant bit first, and the bench's slave samples on the rising edge.

Top module: `sfh_host`

## Requirements
- R1: After reset, control/status (offset 0x00) reads 0x52: bit 1 ready, bit 4 read FIFO empty and bit 6 write FIFO empty are set, chip select is off (`cs_n` high). Configuration (offset 0x04) reads 0.
- R2: These registers read back what was written:
  - instruction at 0x10 (32 bits)
  - address at 0x14 (32 bits)
  - read-mode at 0x18 (bits 7:0)
  - header count at 0x1C (bits 5:0)
  - data count at 0x20 (bits 15:0)
- R3: Writing configuration bit 15 (start) takes effect only while control bit 0 (chip select enable, `cs_n` = inverse) is set. Otherwise bit 15 reads back 0 and no serial clock is produced.
- R4: The header sends header-count bits [3:0] instruction bytes and then bits [5:4] address bytes. Instruction bytes come from the instruction register, most significant used byte first. Address bytes are sent most significant byte first, so two address bytes of 0xABCDEF are 0xCD then 0xEF. Each byte is sent MSB first.
- R5: With configuration bit 13 set (write direction), the data phase sends write-FIFO bytes in order. A stop (configuration bit 14) does not end the transfer until the FIFO has drained. Bits 15 and 14 read 1 until then.
- R6: The write FIFO (data-out, 0x08) holds 8 bytes. Control bit 7 flags it full, and a write to data-out while it is full is dropped.
- R7: With bit 13 clear and a nonzero data count, exactly that many bytes are clocked in after the header, and the start bit stays set. Each read of data-in (0x0C) returns the oldest byte in bits [7:0] and removes it. A read of an empty FIFO returns 0.
- R8: With a data count of 0, reading continues without limit. It pauses between bytes while the 8-byte read FIFO is full.
- R9: A stop request, or clearing chip select enable, ends the transfer at the next byte boundary. The start and stop bits then clear by themselves.
- R10: Writing configuration bit 9 empties both FIFOs. Bit 9 reads 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe (pops data-in) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| cs_n | output | 1 | Flash chip select, active low |
| sck | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to flash |
| miso | input | 1 | Serial data from flash |

## Verification
A wrong byte counter or state shows up on the serial pins within one byte time, about 33 system clocks. It appears as an extra or missing header or data byte, or as address bytes in the wrong order in the captured wire log. A read FIFO pointer error shows up at the next data-in read, as a misordered or stale byte. A start or stop handshake fault shows up as a start bit that never clears, which the bounded poll reports, or one that clears while the write FIFO still holds data.

// File: rtl/sfh_pkg.sv
package sfh_pkg;
  // register byte offsets
  localparam logic [7:0] OFS_CTRL   = 8'h00;
  localparam logic [7:0] OFS_CFG    = 8'h04;
  localparam logic [7:0] OFS_DOUT   = 8'h08;
  localparam logic [7:0] OFS_DIN    = 8'h0C;
  localparam logic [7:0] OFS_INSTR  = 8'h10;
  localparam logic [7:0] OFS_ADDR   = 8'h14;
  localparam logic [7:0] OFS_RDMODE = 8'h18;
  localparam logic [7:0] OFS_HDR    = 8'h1C;
  localparam logic [7:0] OFS_DCNT   = 8'h20;

  // configuration bit positions
  localparam int CFG_FLUSH = 9;
  localparam int CFG_MODE  = 10;
  localparam int CFG_DIR   = 13;
  localparam int CFG_STOP  = 14;
  localparam int CFG_START = 15;

  typedef enum logic [2:0] {
    SEQ_IDLE, SEQ_INS, SEQ_ADR, SEQ_DAT, SEQ_HOLD
  } seq_state_e;
endpackage

// File: rtl/sfh_fifo.sv
module sfh_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp_q, rp_q, wp_d, rp_d;
  logic         do_push, do_pop;

  assign empty   = (wp_q == rp_q);
  assign full    = (wp_q[AW] != rp_q[AW]) && (wp_q[AW-1:0] == rp_q[AW-1:0]);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign rdata   = mem[rp_q[AW-1:0]];

  always_comb begin
    wp_d = wp_q;
    rp_d = rp_q;
    if (flush) begin
      wp_d = '0;
      rp_d = '0;
    end else begin
      if (do_push) wp_d = wp_q + 1'b1;
      if (do_pop)  rp_d = rp_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      wp_q <= wp_d;
      rp_q <= rp_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q[AW-1:0]] <= wdata;
  end
endmodule

// File: rtl/sfh_shift.sv
module sfh_shift #(
  parameter int DIV = 4   // even, at least 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [7:0] tx,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx,
  output logic       sck,
  output logic       mosi,
  input  logic       miso
);
  localparam int HALF = DIV / 2;
  localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] CNT_RISE = CW'(HALF - 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(DIV - 1);

  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [2:0]    bit_q, bit_d;
  logic [7:0]    tx_q, tx_d, rx_q, rx_d;

  assign busy = busy_q;
  assign done = busy_q && (cnt_q == CNT_LAST) && (bit_q == 3'd7);
  assign rx   = rx_q;
  assign sck  = busy_q && (cnt_q >= CW'(HALF));
  assign mosi = busy_q && tx_q[7];

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    bit_d  = bit_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    if (!busy_q) begin
      if (go) begin
        busy_d = 1'b1;
        cnt_d  = '0;
        bit_d  = '0;
        tx_d   = tx;
      end
    end else begin
      if (cnt_q == CNT_RISE) rx_d = {rx_q[6:0], miso};
      if (cnt_q == CNT_LAST) begin
        cnt_d = '0;
        tx_d  = {tx_q[6:0], 1'b0};
        if (bit_q == 3'd7) busy_d = 1'b0;
        else               bit_d  = bit_q + 3'd1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      bit_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      bit_q  <= bit_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
    end
  end
endmodule

// File: rtl/sfh_host.sv
module sfh_host
  import sfh_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int CLK_DIV    = 4,
  parameter int FIFO_DEPTH = 8,
  parameter int CNT_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              cs_n,
  output logic              sck,
  output logic              mosi,
  input  logic              miso
);
  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  // bus decode
  logic wr_ctrl, wr_cfg, wr_dout, wr_instr, wr_addr, wr_rdm, wr_hdr, wr_dcnt, rd_din;
  assign wr_ctrl  = bus_we && (bus_addr == ADDR_W'(OFS_CTRL));
  assign wr_cfg   = bus_we && (bus_addr == ADDR_W'(OFS_CFG));
  assign wr_dout  = bus_we && (bus_addr == ADDR_W'(OFS_DOUT));
  assign wr_instr = bus_we && (bus_addr == ADDR_W'(OFS_INSTR));
  assign wr_addr  = bus_we && (bus_addr == ADDR_W'(OFS_ADDR));
  assign wr_rdm   = bus_we && (bus_addr == ADDR_W'(OFS_RDMODE));
  assign wr_hdr   = bus_we && (bus_addr == ADDR_W'(OFS_HDR));
  assign wr_dcnt  = bus_we && (bus_addr == ADDR_W'(OFS_DCNT));
  assign rd_din   = bus_re && (bus_addr == ADDR_W'(OFS_DIN));

  // register state
  logic             cs_en_q, cs_dly_q, dir_q, start_q, stop_q, flush_q;
  logic [2:0]       mode_q;
  logic [31:0]      instr_q, addr_q;
  logic [7:0]       rdmode_q;
  logic [3:0]       nins_q;
  logic [1:0]       nadr_q;
  logic [CNT_W-1:0] dcnt_q;

  // sequencer state
  seq_state_e       st_q, st_d;
  logic [3:0]       ins_left_q, ins_left_d;
  logic [1:0]       adr_left_q, adr_left_d;
  logic [CNT_W-1:0] xcnt_q, xcnt_d;
  logic             rd_infl_q, rd_infl_d;

  // datapath links
  logic       eng_go, eng_busy, eng_done;
  logic [7:0] eng_tx, eng_rx;
  logic       wf_pop, wf_empty, wf_full, rf_push, rf_empty, rf_full;
  logic [7:0] wf_rdata, rf_rdata;
  logic       finish, stop_eff, ready;
  logic [3:0] ins_idx;
  logic [1:0] adr_idx;

  assign stop_eff = stop_q || !cs_en_q;
  assign ready    = (cs_en_q == cs_dly_q) && !eng_busy;
  assign rf_push  = eng_done && rd_infl_q;
  assign ins_idx  = ins_left_q - 4'd1;
  assign adr_idx  = adr_left_q - 2'd1;
  assign cs_n     = !cs_en_q;

  sfh_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_wfifo (
    .clk(clk), .rst_n(rst_ni), .flush(flush_q),
    .push(wr_dout), .wdata(bus_wdata[7:0]),
    .pop(wf_pop), .rdata(wf_rdata), .empty(wf_empty), .full(wf_full)
  );

  sfh_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rfifo (
    .clk(clk), .rst_n(rst_ni), .flush(flush_q),
    .push(rf_push), .wdata(eng_rx),
    .pop(rd_din), .rdata(rf_rdata), .empty(rf_empty), .full(rf_full)
  );

  sfh_shift #(.DIV(CLK_DIV)) u_shift (
    .clk(clk), .rst_n(rst_ni), .go(eng_go), .tx(eng_tx),
    .busy(eng_busy), .done(eng_done), .rx(eng_rx),
    .sck(sck), .mosi(mosi), .miso(miso)
  );

  // sequencer next state
  always_comb begin
    st_d       = st_q;
    ins_left_d = ins_left_q;
    adr_left_d = adr_left_q;
    xcnt_d     = xcnt_q;
    rd_infl_d  = eng_done ? 1'b0 : rd_infl_q;
    eng_go     = 1'b0;
    eng_tx     = 8'h00;
    wf_pop     = 1'b0;
    finish     = 1'b0;
    unique case (st_q)
      SEQ_IDLE: if (start_q) begin
        if (!cs_en_q) finish = 1'b1;
        else begin
          ins_left_d = nins_q;
          adr_left_d = nadr_q;
          xcnt_d     = '0;
          st_d = (nins_q != 4'd0) ? SEQ_INS : (nadr_q != 2'd0) ? SEQ_ADR : SEQ_DAT;
        end
      end
      SEQ_INS: if (!eng_busy) begin
        eng_go     = 1'b1;
        eng_tx     = 8'(instr_q >> {ins_idx, 3'b000});
        ins_left_d = ins_idx;
        if (ins_left_q == 4'd1) st_d = (nadr_q != 2'd0) ? SEQ_ADR : SEQ_DAT;
      end
      SEQ_ADR: if (!eng_busy) begin
        eng_go     = 1'b1;
        eng_tx     = 8'(addr_q >> {adr_idx, 3'b000});
        adr_left_d = adr_idx;
        if (adr_left_q == 2'd1) st_d = SEQ_DAT;
      end
      SEQ_DAT: if (!eng_busy) begin
        if (dir_q) begin
          if (!wf_empty) begin
            eng_go = 1'b1;
            eng_tx = wf_rdata;
            wf_pop = 1'b1;
          end else if (stop_eff) finish = 1'b1;
        end else if (stop_eff) finish = 1'b1;
        else if ((dcnt_q != '0) && (xcnt_q == dcnt_q)) st_d = SEQ_HOLD;
        else if (!rf_full) begin
          eng_go    = 1'b1;
          rd_infl_d = 1'b1;
          xcnt_d    = xcnt_q + 1'b1;
        end
      end
      SEQ_HOLD: if (stop_eff) finish = 1'b1;
      default: st_d = SEQ_IDLE;
    endcase
    if (finish) st_d = SEQ_IDLE;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= SEQ_IDLE;
      ins_left_q <= '0;
      adr_left_q <= '0;
      xcnt_q     <= '0;
      rd_infl_q  <= 1'b0;
    end else begin
      st_q       <= st_d;
      ins_left_q <= ins_left_d;
      adr_left_q <= adr_left_d;
      xcnt_q     <= xcnt_d;
      rd_infl_q  <= rd_infl_d;
    end
  end

  // register file
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_en_q  <= 1'b0;
      cs_dly_q <= 1'b0;
      dir_q    <= 1'b0;
      mode_q   <= '0;
      start_q  <= 1'b0;
      stop_q   <= 1'b0;
      flush_q  <= 1'b0;
      instr_q  <= '0;
      addr_q   <= '0;
      rdmode_q <= '0;
      nins_q   <= '0;
      nadr_q   <= '0;
      dcnt_q   <= '0;
    end else begin
      cs_dly_q <= cs_en_q;
      flush_q  <= wr_cfg && bus_wdata[CFG_FLUSH];
      if (wr_ctrl) cs_en_q <= bus_wdata[0];
      if (wr_cfg) begin
        dir_q  <= bus_wdata[CFG_DIR];
        mode_q <= bus_wdata[CFG_MODE +: 3];
      end
      if (finish) begin
        start_q <= 1'b0;
        stop_q  <= 1'b0;
      end else begin
        if (wr_cfg && bus_wdata[CFG_START] && cs_en_q) start_q <= 1'b1;
        if (wr_cfg && bus_wdata[CFG_STOP] && start_q)  stop_q  <= 1'b1;
      end
      if (wr_instr) instr_q  <= bus_wdata;
      if (wr_addr)  addr_q   <= bus_wdata;
      if (wr_rdm)   rdmode_q <= bus_wdata[7:0];
      if (wr_hdr) begin
        nins_q <= bus_wdata[3:0];
        nadr_q <= bus_wdata[5:4];
      end
      if (wr_dcnt) dcnt_q <= bus_wdata[CNT_W-1:0];
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      ADDR_W'(OFS_CTRL):   bus_rdata = {24'd0, wf_full, wf_empty, 1'b0, rf_empty, 2'b00, ready, cs_en_q};
      ADDR_W'(OFS_CFG):    bus_rdata = {16'd0, start_q, stop_q, dir_q, mode_q, flush_q, 9'd0};
      ADDR_W'(OFS_DIN):    bus_rdata = rf_empty ? 32'd0 : {24'd0, rf_rdata};
      ADDR_W'(OFS_INSTR):  bus_rdata = instr_q;
      ADDR_W'(OFS_ADDR):   bus_rdata = addr_q;
      ADDR_W'(OFS_RDMODE): bus_rdata = {24'd0, rdmode_q};
      ADDR_W'(OFS_HDR):    bus_rdata = {26'd0, nadr_q, nins_q};
      ADDR_W'(OFS_DCNT):   bus_rdata = 32'(dcnt_q);
      default:             bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/sfh_host_chk.sv
module sfh_host_chk
  import sfh_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic              bus_re,
  input logic [31:0]       bus_rdata,
  input logic              wf_full,
  input logic              wf_pop,
  input logic              wf_empty,
  input logic              rf_empty,
  input logic              flush_q,
  input logic              start_q,
  input logic              cs_en_q,
  input logic              eng_busy
);
  AST_FULL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_we && bus_addr == ADDR_W'(OFS_DOUT) && wf_full && !wf_pop && !flush_q) |=> wf_full); // R6

  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_re && bus_addr == ADDR_W'(OFS_DIN) && rf_empty) |-> (bus_rdata == 32'd0)); // R7

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_ni)
    flush_q |=> (rf_empty && wf_empty)); // R10

  AST_START_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(start_q) |-> $past(cs_en_q)); // R3

  AST_END_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(start_q) |-> $past(!eng_busy)); // R9
endmodule

bind sfh_host sfh_host_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_ni(rst_ni), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_re(bus_re), .bus_rdata(bus_rdata), .wf_full(wf_full), .wf_pop(wf_pop),
  .wf_empty(wf_empty), .rf_empty(rf_empty), .flush_q(flush_q),
  .start_q(start_q), .cs_en_q(cs_en_q), .eng_busy(eng_busy)
);

// File: tb/sfh_host_bench.sv
module sfh_host_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        cs_n, sck, mosi, miso;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done_flag = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  sfh_host u_sfh_host (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cs_n(cs_n), .sck(sck),
    .mosi(mosi), .miso(miso)
  );

  // flash slave model: response byte k of each select window
  function automatic logic [7:0] resp8(int k);
    return 8'(8'h3C + 17 * k);
  endfunction

  int         sbit = 0;
  int         sbyte = 0;
  int         mcount = 0;
  logic [7:0] sh = 8'h00;
  logic [7:0] mlog [0:63];
  logic [7:0] cur;
  assign cur  = resp8(sbyte);
  assign miso = cur[3'(7 - sbit)];

  always @(posedge sck or negedge sck or posedge cs_n) begin
    if (cs_n === 1'b1) begin
      sbit  = 0;
      sbyte = 0;
    end else if (sck) begin
      sh = {sh[6:0], mosi};
    end else if (sbit == 7) begin
      mlog[mcount % 64] = sh;
      mcount++;
      sbit = 0;
      sbyte++;
    end else begin
      sbit++;
    end
  end

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done_flag) begin
      checks++;
      fails++;
      $display("FAIL watchdog (R1..all): actual=hung expected=finished");
      report();
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_start_clear(string req);
    logic [31:0] v;
    v = 32'hFFFF_FFFF;
    for (int i = 0; i < 3000; i++) begin
      rd(8'h04, v);
      if (!v[15]) break;
    end
    chk(req, 32'(v[15]), 32'd0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(8'h00, v); chk("R1 ctrl", v, 32'h52);
    rd(8'h04, v); chk("R1 cfg", v, 32'h0);
    chk("R1 cs_n", 32'(cs_n), 32'd1);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(8'h10, 32'hDEADBEEF); rd(8'h10, v); chk("R2 instr", v, 32'hDEADBEEF);
    wr(8'h14, 32'h12345678); rd(8'h14, v); chk("R2 addr", v, 32'h12345678);
    wr(8'h18, 32'h000000A5); rd(8'h18, v); chk("R2 rdmode", v, 32'hA5);
    wr(8'h1C, 32'h0000003F); rd(8'h1C, v); chk("R2 hdr", v, 32'h3F);
    wr(8'h20, 32'h0000BEEF); rd(8'h20, v); chk("R2 dcnt", v, 32'hBEEF);
  endtask

  task automatic t_start_no_cs();
    logic [31:0] v;
    int base;
    base = mcount;
    wr(8'h00, 32'h0);
    wr(8'h04, 32'h8000);
    rd(8'h04, v); chk("R3 start ignored", v, 32'h0);
    idle(100);
    chk("R3 no clocking", 32'(mcount - base), 32'd0);
  endtask

  task automatic t_write_hdr3();
    logic [31:0] v;
    int base;
    logic [7:0] exp [7];
    exp = '{8'h02, 8'h12, 8'h34, 8'h56, 8'hA1, 8'hB2, 8'hC3};
    wr(8'h00, 32'h1); idle(3);
    wr(8'h04, 32'h0200);
    wr(8'h1C, 32'h31); wr(8'h10, 32'h02); wr(8'h14, 32'h00123456);
    wr(8'h08, 32'hA1); wr(8'h08, 32'hB2); wr(8'h08, 32'hC3);
    base = mcount;
    wr(8'h04, 32'hA000);
    wr(8'h04, 32'hE000);
    rd(8'h04, v); chk("R5 start and stop held", v, 32'hE000);
    wait_start_clear("R5 start self-clears");
    chk("R5 byte count", 32'(mcount - base), 32'd7);
    for (int i = 0; i < 7; i++) chk($sformatf("R4 R5 wire byte %0d", i), 32'(mlog[(base + i) % 64]), 32'(exp[i]));
    rd(8'h04, v); chk("R9 stop cleared", v, 32'h2000);
    wr(8'h00, 32'h0); idle(3);
  endtask

  task automatic t_wfifo_full();
    logic [31:0] v;
    int base;
    wr(8'h00, 32'h1); idle(3);
    wr(8'h04, 32'h0200);
    wr(8'h1C, 32'h0);
    for (int i = 0; i < 10; i++) wr(8'h08, 32'(8'h10 + i));
    rd(8'h00, v); chk("R6 full flag", v, 32'h93);
    base = mcount;
    wr(8'h04, 32'hA000);
    wr(8'h04, 32'hE000);
    wait_start_clear("R6 transfer ends");
    chk("R6 only 8 bytes", 32'(mcount - base), 32'd8);
    for (int i = 0; i < 8; i++) chk($sformatf("R6 byte %0d", i), 32'(mlog[(base + i) % 64]), 32'(8'h10 + i));
    wr(8'h00, 32'h0); idle(3);
  endtask

  task automatic t_addr_only();
    int base;
    wr(8'h00, 32'h1); idle(3);
    wr(8'h04, 32'h0200);
    wr(8'h1C, 32'h20); wr(8'h14, 32'h00ABCDEF);
    wr(8'h08, 32'h77);
    base = mcount;
    wr(8'h04, 32'hA000);
    wr(8'h04, 32'hE000);
    wait_start_clear("R4 addr-only ends");
    chk("R4 addr-only count", 32'(mcount - base), 32'd3);
    chk("R4 addr hi", 32'(mlog[base % 64]), 32'hCD);
    chk("R4 addr lo", 32'(mlog[(base + 1) % 64]), 32'hEF);
    chk("R4 data", 32'(mlog[(base + 2) % 64]), 32'h77);
    wr(8'h00, 32'h0); idle(3);
  endtask

  task automatic t_read_count();
    logic [31:0] v;
    int base;
    wr(8'h00, 32'h1); idle(3);
    wr(8'h04, 32'h0200);
    wr(8'h1C, 32'h01); wr(8'h10, 32'h9F); wr(8'h20, 32'd3);
    base = mcount;
    wr(8'h04, 32'h8000);
    idle(300);
    rd(8'h04, v); chk("R7 start held after count", 32'(v[15]), 32'd1);
    chk("R7 wire bytes", 32'(mcount - base), 32'd4);
    chk("R4 read instr", 32'(mlog[base % 64]), 32'h9F);
    for (int i = 1; i <= 3; i++) begin
      rd(8'h0C, v); chk($sformatf("R7 din %0d", i), v, 32'(resp8(i)));
    end
    rd(8'h0C, v); chk("R7 empty read", v, 32'h0);
    wr(8'h00, 32'h0);
    wait_start_clear("R9 cs release ends");
  endtask

  task automatic t_read_cont();
    logic [31:0] v;
    int base;
    wr(8'h00, 32'h1); idle(3);
    wr(8'h04, 32'h0200);
    wr(8'h1C, 32'h01); wr(8'h10, 32'h05); wr(8'h20, 32'd0);
    base = mcount;
    wr(8'h04, 32'h8000);
    idle(700);
    chk("R8 pause when full", 32'(mcount - base), 32'd9);
    for (int i = 1; i <= 8; i++) begin
      rd(8'h0C, v); chk($sformatf("R8 din %0d", i), v, 32'(resp8(i)));
    end
    idle(100);
    wr(8'h04, 32'hC000);
    wait_start_clear("R9 stop ends read");
    rd(8'h00, v); chk("R8 resumed data", 32'(v[4]), 32'd0);
    wr(8'h04, 32'h0200);
    rd(8'h04, v); chk("R10 flush bit clear", 32'(v[9]), 32'd0);
    rd(8'h00, v); chk("R10 fifos empty", v, 32'h53);
    wr(8'h00, 32'h0); idle(3);
  endtask

  initial begin
    idle(5);
    rst_n = 1'b1;
    idle(5);
    t_reset();
    t_regs();
    t_start_no_cs();
    t_write_hdr3();
    t_wfifo_full();
    t_addr_only();
    t_read_count();
    t_read_cont();
    done_flag = 1'b1;
    report();
  end
endmodule